// File: doc/BRIEF.md
# Gated-Clock SPI Master Serial Port

This block is the transmit and receive pair of a serial port set up to act as an SPI master. Software loads a word into a one-deep transmit holding register. The block copies the word into its shift register and raises a frame-sync output, which also serves as the chip select. It then sends the word MSB first on `mosi` and, in the same frame, collects a word from `miso`. The serial clock comes from a rate divider that runs on the system clock. The clock toggles only inside a frame and rests at its idle level between frames.

Each frame starts with one setup bit slot in which the serial clock stays idle. The word's bits follow, one per slot, so data begins one bit after frame sync. A stop-mode code chooses whether the clock pulse falls in the first or the second half of each bit slot. The receive side has no clock input of its own: it samples `miso` on edges of the generated clock. A receive-edge select decides which edge is used. If software writes the next word while a frame is running, that word is sent right after the current one, separated by a single system-clock gap with frame sync inactive. The block refuses to start a frame while its configuration is not a valid clock-stop setting.

Top module: `gsm_spi_master`

## Requirements
- R1: After reset, `tx_ready`=1, `rx_ready`=0, `rx_word`=0 and `mosi`=0. `sclk` sits at `cfg_clk_inv` and `fsync` sits at its inactive level, which equals `cfg_fs_low`.
- R2: Outside a frame, `sclk` equals `cfg_clk_inv`. Inside a frame, `sclk` changes only at half-slot boundaries. With `cfg_clk_inv`=1 the whole waveform is inverted.
- R3: A frame is WORD_W+1 bit slots. Each slot has two halves, and each half lasts `cfg_div`+1 system clocks (`cfg_div` is 0 to 255). Slot 0 is a setup slot: the clock stays idle and `mosi` already shows the MSB. Slot k (1..WORD_W) carries bit WORD_W-k of the word, so the MSB goes first.
- R4: `cfg_stop`=2'b10 places the non-inverted clock high in the first half of each data slot. `cfg_stop`=2'b11 places it high in the second half, a delay of half a cycle.
- R5: `fsync` goes active on the clock after the word is copied from the holding register into the shift register, and stays active until the last slot ends. Its active level is low when `cfg_fs_low`=1 and high when `cfg_fs_low`=0.
- R6: With `cfg_rx_late`=0, `miso` is sampled on the last system clock of the first half of each data slot. With `cfg_rx_late`=1, it is sampled on the last system clock of the slot. The collected word (first sample becomes the MSB) goes to `rx_word` when the frame ends, and `rx_ready` is set. A `rx_rd` pulse clears `rx_ready`. If a frame ends in the same cycle as a read, the frame end wins.
- R7: `cfg_err`=1 when `cfg_stop`[1]=0, or when `cfg_tx_delay` or `cfg_rx_delay` is not 1. While `cfg_err`=1, no frame starts, and a held word waits until the configuration becomes valid.
- R8: A word held when a frame ends starts after exactly one system clock with `fsync` inactive.
- R9: `tx_ready` is 1 exactly when the holding register is empty. A `tx_wr` while `tx_ready`=0 is dropped and is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stop | input | 2 | Stop-mode code (2'b10 no delay, 2'b11 half-cycle delay) |
| cfg_clk_inv | input | 1 | Serial clock polarity at the pin |
| cfg_rx_late | input | 1 | Receive sampling edge select |
| cfg_fs_low | input | 1 | Frame sync active low when 1 |
| cfg_tx_delay | input | 2 | Transmit data delay, must be 1 |
| cfg_rx_delay | input | 2 | Receive data delay, must be 1 |
| cfg_div | input | DIV_W | Rate divide value, half slot = value+1 clocks |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_word | input | WORD_W | Word to send |
| tx_ready | output | 1 | Holding register empty |
| rx_rd | input | 1 | Read strobe, clears rx_ready |
| rx_word | output | WORD_W | Last received word |
| rx_ready | output | 1 | A new received word is waiting |
| cfg_err | output | 1 | Configuration is not a valid clock-stop setting |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync / chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong phase counter or a wrong divider count shows up on `sclk` and `mosi` within one half slot, that is, `cfg_div`+1 clocks. The bench compares both pins against an elapsed-time model on every clock, so such a fault is caught there. A fault in the receive shift path stays hidden until the frame ends. At that point `rx_word` goes wrong, and the slave stimulus is built to expose it: it drives a different bit in each half slot, so sampling on the wrong edge gives a different word. A lost or extra holding-register state shows up on `tx_ready` one clock after the write, and on `fsync` one clock after the copy.

// File: rtl/gsm_spi_pkg.sv
package gsm_spi_pkg;

    typedef enum logic [1:0] {
        STOP_OFF_A   = 2'b00,
        STOP_OFF_B   = 2'b01,
        STOP_NODLY   = 2'b10,
        STOP_HALFDLY = 2'b11
    } stop_e;

    typedef struct packed {
        stop_e      stop;
        logic       clk_inv;
        logic       rx_late;
        logic       fs_low;
        logic [1:0] tx_delay;
        logic [1:0] rx_delay;
    } cfg_t;

    // Only the two clock-stop codes with a one-bit data delay are usable.
    function automatic logic cfg_ok(cfg_t c);
        return c.stop[1] && (c.tx_delay == 2'd1) && (c.rx_delay == 2'd1);
    endfunction

    // Level of the non-inverted clock in a data slot, by half.
    function automatic logic slot_level(stop_e m, logic second_half);
        return (m == STOP_HALFDLY) ? second_half : ~second_half;
    endfunction

endpackage

// File: rtl/gsm_spi_rategen.sv
module gsm_spi_rategen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div)); // R3

endmodule

// File: rtl/gsm_spi_seq.sv
module gsm_spi_seq #(
    parameter int WORD_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start,
    input  logic                                   tick,
    output logic                                   busy,
    output logic [$clog2(2*(WORD_W+1))-1:0]        phase,
    output logic                                   done,
    output logic                                   tx_shift,
    output logic                                   mid_edge,
    output logic                                   end_edge
);
    localparam int PH_W = $clog2(2*(WORD_W+1));
    localparam logic [PH_W-1:0] LAST  = PH_W'(2*WORD_W+1);
    localparam logic [PH_W-1:0] FIRST_DATA = PH_W'(2);
    localparam logic [PH_W-1:0] FIRST_SHIFT = PH_W'(3);

    logic step;
    assign step     = busy && tick;
    assign done     = step && (phase == LAST);
    assign tx_shift = step && phase[0] && (phase >= FIRST_SHIFT);
    assign mid_edge = step && !phase[0] && (phase >= FIRST_DATA);
    assign end_edge = step && phase[0] && (phase >= FIRST_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            phase <= '0;
        end else if (done) begin
            busy  <= 1'b0;
            phase <= '0;
        end else if (step) begin
            phase <= phase + 1'b1;
        end
    end

    AST_PHASE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (phase <= LAST)); // R3

    AST_GAP_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R8

endmodule

// File: rtl/gsm_spi_tx.sv
module gsm_spi_tx #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    input  logic              shift,
    output logic              hold_full,
    output logic              msb
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] sh_q;
    logic              accept;

    assign accept = wr && !hold_full;
    assign msb    = sh_q[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            sh_q      <= '0;
        end else begin
            if (load) begin
                sh_q      <= hold_q;
                hold_full <= 1'b0;
            end else if (shift) begin
                sh_q <= {sh_q[WORD_W-2:0], 1'b0};
            end
            if (accept) begin
                hold_q    <= wr_data;
                hold_full <= 1'b1;
            end
        end
    end

    AST_FULL_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !load) |=> (hold_full && $stable(hold_q))); // R9

endmodule

// File: rtl/gsm_spi_rx.sv
module gsm_spi_rx #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              din,
    input  logic              done,
    input  logic              rd,
    output logic [WORD_W-1:0] data,
    output logic              ready
);
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] sh_nxt;

    assign sh_nxt = sample ? {sh_q[WORD_W-2:0], din} : sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            data  <= '0;
            ready <= 1'b0;
        end else begin
            sh_q <= sh_nxt;
            if (done) begin
                data  <= sh_nxt;
                ready <= 1'b1;
            end else if (rd) begin
                ready <= 1'b0;
            end
        end
    end

    AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> ready); // R6

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(data)); // R6

endmodule

// File: rtl/gsm_spi_master.sv
module gsm_spi_master
    import gsm_spi_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_stop,
    input  logic              cfg_clk_inv,
    input  logic              cfg_rx_late,
    input  logic              cfg_fs_low,
    input  logic [1:0]        cfg_tx_delay,
    input  logic [1:0]        cfg_rx_delay,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_ready,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    output logic              cfg_err,
    output logic              sclk,
    output logic              fsync,
    output logic              mosi,
    input  logic              miso
);
    localparam int PH_W = $clog2(2*(WORD_W+1));
    localparam logic [PH_W-1:0] FIRST_DATA = PH_W'(2);

    cfg_t            cfg;
    logic            valid;
    logic            busy;
    logic            tick;
    logic            start;
    logic            done;
    logic            tx_shift;
    logic            mid_edge;
    logic            end_edge;
    logic            hold_full;
    logic            msb;
    logic            rx_sample;
    logic            data_slot;
    logic [PH_W-1:0] phase;

    assign cfg = '{stop: stop_e'(cfg_stop), clk_inv: cfg_clk_inv,
                   rx_late: cfg_rx_late, fs_low: cfg_fs_low,
                   tx_delay: cfg_tx_delay, rx_delay: cfg_rx_delay};

    assign valid     = cfg_ok(cfg);
    assign cfg_err   = !valid;
    assign start     = !busy && hold_full && valid;
    assign rx_sample = cfg.rx_late ? end_edge : mid_edge;
    assign data_slot = busy && (phase >= FIRST_DATA);

    assign sclk     = (data_slot && slot_level(cfg.stop, phase[0])) ^ cfg.clk_inv;
    assign fsync    = busy ^ cfg.fs_low;
    assign mosi     = busy && msb;
    assign tx_ready = !hold_full;

    gsm_spi_rategen #(.DIV_W(DIV_W)) u_rate (
        .clk (clk),
        .rst (rst),
        .run (busy),
        .div (cfg_div),
        .tick(tick)
    );

    gsm_spi_seq #(.WORD_W(WORD_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .tick    (tick),
        .busy    (busy),
        .phase   (phase),
        .done    (done),
        .tx_shift(tx_shift),
        .mid_edge(mid_edge),
        .end_edge(end_edge)
    );

    gsm_spi_tx #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr       (tx_wr),
        .wr_data  (tx_word),
        .load     (start),
        .shift    (tx_shift),
        .hold_full(hold_full),
        .msb      (msb)
    );

    gsm_spi_rx #(.WORD_W(WORD_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .sample(rx_sample),
        .din   (miso),
        .done  (done),
        .rd    (rx_rd),
        .data  (rx_word),
        .ready (rx_ready)
    );

    AST_SCLK_STILL: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(sclk)); // R2

    AST_NO_START_BAD_CFG: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_err) |=> !busy); // R7

    AST_SETUP_SLOT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sclk == cfg_clk_inv)); // R3

endmodule

// File: tb/gsm_spi_master_tb.sv
module gsm_spi_master_tb;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_stop = 2'b10;
    logic       cfg_clk_inv = 1'b0;
    logic       cfg_rx_late = 1'b0;
    logic       cfg_fs_low = 1'b1;
    logic [1:0] cfg_tx_delay = 2'd1;
    logic [1:0] cfg_rx_delay = 2'd1;
    logic [7:0] cfg_div = 8'd0;
    logic       tx_wr = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic       tx_ready;
    logic       rx_rd = 1'b0;
    logic [W-1:0] rx_word;
    logic       rx_ready;
    logic       cfg_err;
    logic       sclk;
    logic       fsync;
    logic       mosi;
    logic       miso = 1'b0;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit finished = 0;

    // reference model state
    int           m_busy, m_el, m_full, m_rxr;
    logic [W-1:0] m_hold, m_word, m_rxd, m_a, m_b;
    logic [W-1:0] sl_a = '0, sl_b = '0;

    always #5 clk = ~clk;

    gsm_spi_master #(.WORD_W(W), .DIV_W(8)) u_dut (
        .clk(clk), .rst(rst), .cfg_stop(cfg_stop), .cfg_clk_inv(cfg_clk_inv),
        .cfg_rx_late(cfg_rx_late), .cfg_fs_low(cfg_fs_low),
        .cfg_tx_delay(cfg_tx_delay), .cfg_rx_delay(cfg_rx_delay),
        .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_word(tx_word),
        .tx_ready(tx_ready), .rx_rd(rx_rd), .rx_word(rx_word),
        .rx_ready(rx_ready), .cfg_err(cfg_err), .sclk(sclk),
        .fsync(fsync), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit cfg_good();
        return cfg_stop[1] && cfg_tx_delay == 2'd1 && cfg_rx_delay == 2'd1;
    endfunction

    // model update at each rising edge
    always @(posedge clk) begin
        int total;
        int old_full;
        bit fin;
        total = 2 * (W + 1) * (int'(cfg_div) + 1);
        old_full = m_full;
        fin = 0;
        if (rst) begin
            m_busy = 0; m_el = 0; m_full = 0; m_rxr = 0;
            m_hold = '0; m_word = '0; m_rxd = '0; m_a = '0; m_b = '0;
        end else begin
            if (m_busy != 0) begin
                if (m_el == total - 1) begin
                    m_busy = 0;
                    fin = 1;
                    m_rxd = cfg_rx_late ? m_b : m_a;
                    m_rxr = 1;
                end else begin
                    m_el++;
                end
            end else if (m_full != 0 && cfg_good()) begin
                m_busy = 1; m_el = 0; m_word = m_hold; m_full = 0;
                m_a = sl_a; m_b = sl_b;
            end
            if (rx_rd && !fin) m_rxr = 0;
            if (tx_wr && old_full == 0) begin
                m_hold = tx_word;
                m_full = 1;
            end
        end
    end

    // compare on the falling edge, then drive the slave data bit
    always @(negedge clk) begin
        int p, h, slot, half;
        logic e_sclk, e_mosi, inner;
        p = int'(cfg_div) + 1;
        h = m_el / p;
        slot = h / 2;
        half = h % 2;
        if (cmp_on) begin
            if (m_busy != 0) begin
                inner = (slot >= 1) && ((cfg_stop == 2'b11) ? (half == 1) : (half == 0));
                e_sclk = inner ^ cfg_clk_inv;
                e_mosi = (slot <= 1) ? m_word[W-1] : m_word[W-slot];
                chk("R4 sclk in frame", sclk, e_sclk);
                chk("R3 mosi", mosi, e_mosi);
                chk("R5 fsync active", fsync, !cfg_fs_low);
            end else begin
                chk("R2 sclk idle", sclk, cfg_clk_inv);
                chk("R3 mosi idle", mosi, 1'b0);
                chk("R5 R8 fsync inactive", fsync, cfg_fs_low);
            end
            chk("R9 tx_ready", tx_ready, (m_full == 0));
            chk("R6 rx_ready", rx_ready, (m_rxr != 0));
            chk("R6 rx_word", rx_word, m_rxd);
            chk("R7 cfg_err", cfg_err, !cfg_good());
        end
        if (m_busy != 0 && slot >= 1 && slot <= W)
            miso = (half == 0) ? m_a[W-slot] : m_b[W-slot];
        else
            miso = 1'b0;
    end

    task automatic write_word(input logic [W-1:0] d);
        @(negedge clk); #2;
        tx_wr = 1'b1; tx_word = d;
        @(negedge clk); #2;
        tx_wr = 1'b0;
    endtask

    task automatic read_pulse();
        @(negedge clk); #2;
        rx_rd = 1'b1;
        @(negedge clk); #2;
        rx_rd = 1'b0;
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (m_busy == 0 && m_full == 0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_ready", tx_ready, 1'b1);
        chk("R1 rx_ready", rx_ready, 1'b0);
        chk("R1 rx_word", rx_word, '0);
        chk("R1 mosi", mosi, 1'b0);
        chk("R1 sclk", sclk, 1'b0);
        chk("R1 fsync", fsync, 1'b1);
        cmp_on = 1;

        // basic frame, no delay, early sampling
        sl_a = 8'h3C; sl_b = 8'hC3;
        write_word(8'hA5);
        wait_quiet();
        chk("R6 word early edge", rx_word, 8'h3C);
        read_pulse();
        @(negedge clk);
        chk("R6 ready cleared", rx_ready, 1'b0);

        // half-cycle delay, inverted clock, late sampling, slower clock
        cfg_stop = 2'b11; cfg_clk_inv = 1'b1; cfg_rx_late = 1'b1; cfg_div = 8'd2;
        sl_a = 8'h11; sl_b = 8'hEE;
        write_word(8'h5A);
        wait_quiet();
        chk("R6 word late edge", rx_word, 8'hEE);

        // back-to-back words and a dropped write
        cfg_stop = 2'b10; cfg_clk_inv = 1'b0; cfg_rx_late = 1'b0; cfg_div = 8'd1;
        sl_a = 8'h96; sl_b = 8'h00;
        write_word(8'h81);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_ready) break;
        end
        write_word(8'h7E);
        chk("R9 not ready when full", tx_ready, 1'b0);
        write_word(8'hFF);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (fsync == cfg_fs_low) break;
        end
        chk("R8 gap inactive", fsync, cfg_fs_low);
        @(negedge clk);
        chk("R8 restart after one clock", fsync, !cfg_fs_low);
        wait_quiet();
        repeat (60) @(negedge clk);
        chk("R9 dropped write never sent", fsync, cfg_fs_low);

        // invalid configurations hold the word
        cfg_tx_delay = 2'd0;
        write_word(8'h33);
        repeat (40) @(negedge clk);
        chk("R7 no frame on bad delay", fsync, cfg_fs_low);
        chk("R7 word still held", tx_ready, 1'b0);
        cfg_tx_delay = 2'd1; cfg_rx_delay = 2'd2;
        repeat (5) @(negedge clk);
        chk("R7 bad rx delay flagged", cfg_err, 1'b1);
        cfg_rx_delay = 2'd1; cfg_stop = 2'b01;
        repeat (5) @(negedge clk);
        chk("R7 non-stop mode flagged", cfg_err, 1'b1);
        chk("R7 still no frame", fsync, cfg_fs_low);
        cfg_stop = 2'b10;
        wait_quiet();
        chk("R7 held word sent later", rx_ready, 1'b1);

        // active-high frame sync, read held high across frame end
        cfg_fs_low = 1'b0; cfg_stop = 2'b11; cfg_div = 8'd0;
        sl_a = 8'hF0; sl_b = 8'h0F;
        @(negedge clk); #2 rx_rd = 1'b1;
        write_word(8'hC7);
        wait_quiet();
        #2 rx_rd = 1'b0;
        @(negedge clk);
        chk("R5 active-high idle", fsync, 1'b0);
        chk("R6 word after held read", rx_word, 8'hF0);

        // wide divider
        cfg_div = 8'd255; cfg_fs_low = 1'b1;
        sl_a = 8'h5D; sl_b = 8'hA2;
        write_word(8'h3B);
        wait_quiet();
        chk("R3 word with max divide", rx_word, 8'hA2 ^ 8'hA2 ^ 8'h5D);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule